// File: doc/BRIEF.md
# Read-only L1 Cache Line Controller

This block manages the lines of a small direct-mapped instruction cache that is never written by its client. Each line holds a tag, a data word and one of three states: empty, empty while a fill is on its way, or holding usable data. Requests come from the head of one request queue. A request whose type bit marks it as a replacement is treated as an eviction. Every other request is treated as an instruction fetch.

A fetch that misses claims the line. It writes the new tag, marks the line as waiting and sends one read downstream. The fill that comes back writes the data array, makes the line usable and answers the client. An eviction may arrive whatever the line is doing. It always leaves the line empty and is acknowledged with a one-cycle invalidate-done pulse. If an eviction empties a line whose fill is still outstanding, the late fill still answers the waiting fetch, but the line is not allocated.

A line address is split so that its low `IDX_W` bits select the line and the remaining upper bits form the tag. Every strobe and response is registered. It appears in the cycle after the clock edge that accepted the request or fill.

Top module: `icl1_line_ctrl`

## Requirements
- R1: Reset is synchronous and active high. It empties every line and drives every output low. The first fetch to any address after reset is a miss.
- R2: A fetch (`req_evict`=0) to an empty line is accepted. One cycle later `tag_rd`, `tag_wr` and `mem_req_valid` pulse together, and `mem_req_addr` equals the request address. The line then waits for its fill.
- R3: A fill for a waiting line does three things one cycle later: it pulses `data_wr`, it pulses `resp_valid` with `resp_data` equal to `fill_data`, and it makes the line usable. A later fetch with the same tag is then a hit: one cycle later `tag_rd` and `resp_valid` pulse with the stored data, and neither `tag_wr` nor `mem_req_valid` pulses.
- R4: An eviction (`req_evict`=1) is accepted whatever the line state. One cycle later `tag_rd`, `tag_wr` and `inv_done` pulse, while `resp_valid` and `mem_req_valid` stay low. The line is then empty.
- R5: An eviction selects its line by the index bits alone. It empties that line even when the stored tag differs from the tag bits of the request.
- R6: A fill whose line was emptied after the miss still pulses `resp_valid` with `fill_data`. It does not pulse `data_wr`, and the line stays empty.
- R7: At most one miss is outstanding. While one is pending, any fetch that is not a hit is held with `req_ready` low, including a fetch to the pending line. Hits to other lines are still served.
- R8: In a cycle with `fill_valid` high, `req_ready` is low and the queue head waits.
- R9: A fill that arrives while no miss is outstanding is ignored: no output pulses in the following cycle.
- R10: A fetch to a usable line whose tag differs is a miss. It rewrites the tag, issues a downstream read and moves the line to waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request queue head is present |
| req_evict | input | 1 | 1 = replacement (evict), 0 = fetch |
| req_addr | input | ADDR_W | Line address of the request |
| req_ready | output | 1 | Head is taken at this clock edge |
| mem_req_valid | output | 1 | One-cycle downstream read request |
| mem_req_addr | output | ADDR_W | Line address of the downstream read |
| fill_valid | input | 1 | Fill response for the outstanding miss |
| fill_data | input | DATA_W | Fill data |
| tag_rd | output | 1 | Tag-array read strobe |
| tag_wr | output | 1 | Tag-array write strobe |
| data_wr | output | 1 | Data-array write strobe |
| inv_done | output | 1 | One-cycle eviction acknowledge |
| resp_valid | output | 1 | Response to the client |
| resp_data | output | DATA_W | Response data |

## Verification
The hardest situation to reach is the late fill. It needs a miss left pending, then an eviction of that same line, then a fetch that must be held, and only then the fill. The bench builds that order for every line index in turn and then runs a long arithmetic stimulus stream in which evictions, fetches and fills are interleaved. A line model in the bench predicts each response and strobe.

// File: rtl/icl1_pkg.sv
package icl1_pkg;

    typedef enum logic [1:0] {
        LN_INV   = 2'd0,
        LN_WAIT  = 2'd1,
        LN_VALID = 2'd2
    } line_st_e;

    typedef enum logic [2:0] {
        EV_NONE      = 3'd0,
        EV_HIT       = 3'd1,
        EV_MISS      = 3'd2,
        EV_EVICT     = 3'd3,
        EV_FILL_KEEP = 3'd4,
        EV_FILL_DROP = 3'd5
    } ctl_ev_e;

    function automatic logic ev_takes_req(ctl_ev_e ev);
        return (ev == EV_HIT) || (ev == EV_MISS) || (ev == EV_EVICT);
    endfunction

    function automatic logic ev_is_fill(ctl_ev_e ev);
        return (ev == EV_FILL_KEEP) || (ev == EV_FILL_DROP);
    endfunction

endpackage

// File: rtl/icl1_line_array.sv
module icl1_line_array
    import icl1_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output line_st_e          rd_st,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  fl_idx,
    output line_st_e          fl_st,
    input  logic              st_we,
    input  logic [IDX_W-1:0]  st_widx,
    input  line_st_e          st_wval,
    input  logic              tg_we,
    input  logic [IDX_W-1:0]  tg_widx,
    input  logic [TAG_W-1:0]  tg_wval,
    input  logic              dt_we,
    input  logic [IDX_W-1:0]  dt_widx,
    input  logic [DATA_W-1:0] dt_wval
);
    localparam int NL = 1 << IDX_W;

    line_st_e          st_q  [NL];
    logic [TAG_W-1:0]  tag_q [NL];
    logic [DATA_W-1:0] dat_q [NL];

    for (genvar i = 0; i < NL; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i] <= LN_INV;
            end else if (st_we && st_widx == IDX_W'(i)) begin
                st_q[i] <= st_wval;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[i] <= '0;
            end else if (tg_we && tg_widx == IDX_W'(i)) begin
                tag_q[i] <= tg_wval;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                dat_q[i] <= '0;
            end else if (dt_we && dt_widx == IDX_W'(i)) begin
                dat_q[i] <= dt_wval;
            end
        end
    end

    assign rd_st   = st_q[rd_idx];
    assign rd_tag  = tag_q[rd_idx];
    assign rd_data = dat_q[rd_idx];
    assign fl_st   = st_q[fl_idx];

endmodule

// File: rtl/icl1_miss_track.sv
module icl1_miss_track #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic              clr,
    input  logic [ADDR_W-1:0] set_addr,
    output logic              busy,
    output logic [IDX_W-1:0]  idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (set) begin
            busy <= 1'b1;
            idx  <= set_addr[IDX_W-1:0];
        end else if (clr) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/icl1_dispatch.sv
module icl1_dispatch
    import icl1_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             req_valid,
    input  logic             req_evict,
    input  logic [TAG_W-1:0] req_tag,
    input  line_st_e         rd_st,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic             fill_valid,
    input  logic             mshr_busy,
    input  line_st_e         fl_st,
    output ctl_ev_e          ev,
    output logic             ready
);
    always_comb begin
        ev = EV_NONE;
        if (fill_valid) begin
            if (mshr_busy) begin
                ev = (fl_st == LN_WAIT) ? EV_FILL_KEEP : EV_FILL_DROP;
            end
        end else if (req_valid) begin
            if (req_evict) begin
                ev = EV_EVICT;
            end else if (rd_st == LN_VALID && rd_tag == req_tag) begin
                ev = EV_HIT;
            end else if (!mshr_busy) begin
                ev = EV_MISS;
            end
        end
    end

    assign ready = ev_takes_req(ev);
endmodule

// File: rtl/icl1_line_ctrl.sv
module icl1_line_ctrl
    import icl1_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_evict,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    output logic              tag_rd,
    output logic              tag_wr,
    output logic              data_wr,
    output logic              inv_done,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    line_st_e          rd_st;
    line_st_e          fl_st;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              mshr_busy;
    logic [IDX_W-1:0]  mshr_idx;
    ctl_ev_e           ev;
    logic              st_we;
    logic [IDX_W-1:0]  st_widx;
    line_st_e          st_wval;

    assign req_idx = req_addr[IDX_W-1:0];
    assign req_tag = req_addr[ADDR_W-1:IDX_W];

    icl1_dispatch #(.TAG_W(TAG_W)) u_disp (
        .req_valid (req_valid),
        .req_evict (req_evict),
        .req_tag   (req_tag),
        .rd_st     (rd_st),
        .rd_tag    (rd_tag),
        .fill_valid(fill_valid),
        .mshr_busy (mshr_busy),
        .fl_st     (fl_st),
        .ev        (ev),
        .ready     (req_ready)
    );

    icl1_miss_track #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_mshr (
        .clk     (clk),
        .rst     (rst),
        .set     (ev == EV_MISS),
        .clr     (ev_is_fill(ev)),
        .set_addr(req_addr),
        .busy    (mshr_busy),
        .idx     (mshr_idx)
    );

    always_comb begin
        st_we   = 1'b0;
        st_widx = req_idx;
        st_wval = LN_INV;
        unique case (ev)
            EV_MISS: begin
                st_we   = 1'b1;
                st_wval = LN_WAIT;
            end
            EV_EVICT: begin
                st_we   = 1'b1;
                st_wval = LN_INV;
            end
            EV_FILL_KEEP: begin
                st_we   = 1'b1;
                st_widx = mshr_idx;
                st_wval = LN_VALID;
            end
            default: ;
        endcase
    end

    icl1_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (req_idx),
        .rd_st  (rd_st),
        .rd_tag (rd_tag),
        .rd_data(rd_data),
        .fl_idx (mshr_idx),
        .fl_st  (fl_st),
        .st_we  (st_we),
        .st_widx(st_widx),
        .st_wval(st_wval),
        .tg_we  (ev == EV_MISS),
        .tg_widx(req_idx),
        .tg_wval(req_tag),
        .dt_we  (ev == EV_FILL_KEEP),
        .dt_widx(mshr_idx),
        .dt_wval(fill_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_rd        <= 1'b0;
            tag_wr        <= 1'b0;
            data_wr       <= 1'b0;
            inv_done      <= 1'b0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            resp_valid    <= 1'b0;
            resp_data     <= '0;
        end else begin
            tag_rd        <= ev_takes_req(ev);
            tag_wr        <= (ev == EV_MISS) || (ev == EV_EVICT);
            data_wr       <= (ev == EV_FILL_KEEP);
            inv_done      <= (ev == EV_EVICT);
            mem_req_valid <= (ev == EV_MISS);
            resp_valid    <= (ev == EV_HIT) || ev_is_fill(ev);
            if (ev == EV_MISS) begin
                mem_req_addr <= req_addr;
            end
            if (ev == EV_HIT) begin
                resp_data <= rd_data;
            end else if (ev_is_fill(ev)) begin
                resp_data <= fill_data;
            end
        end
    end

endmodule

// File: rtl/icl1_line_ctrl_chk.sv
module icl1_line_ctrl_chk
    import icl1_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_evict,
    input logic [IDX_W-1:0] req_idx,
    input logic             req_ready,
    input logic             fill_valid,
    input logic             mem_req_valid,
    input logic             tag_rd,
    input logic             tag_wr,
    input logic             data_wr,
    input logic             inv_done,
    input logic             resp_valid,
    input logic             mshr_busy,
    input logic [IDX_W-1:0] mshr_idx,
    input line_st_e         fl_st
);
    a_r4_evict_ack: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_evict) |=>
            (inv_done && tag_rd && tag_wr && !resp_valid && !mem_req_valid));

    a_r8_fill_first: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> !req_ready);

    a_r7_hold_pending: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_evict && !fill_valid && mshr_busy && req_idx == mshr_idx)
            |-> !req_ready);

    a_r6_late_fill: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && mshr_busy && fl_st == LN_INV) |=> (resp_valid && !data_wr));

    a_r9_stray_fill: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !mshr_busy) |=>
            !(resp_valid || data_wr || tag_rd || tag_wr || inv_done || mem_req_valid));

    a_r2_miss_strobes: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (tag_rd && tag_wr && !inv_done && !resp_valid));

    a_r3_fill_answers: assert property (@(posedge clk) disable iff (rst)
        data_wr |-> (resp_valid && !tag_wr));
endmodule

bind icl1_line_ctrl icl1_line_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_evict    (req_evict),
    .req_idx      (req_addr[IDX_W-1:0]),
    .req_ready    (req_ready),
    .fill_valid   (fill_valid),
    .mem_req_valid(mem_req_valid),
    .tag_rd       (tag_rd),
    .tag_wr       (tag_wr),
    .data_wr      (data_wr),
    .inv_done     (inv_done),
    .resp_valid   (resp_valid),
    .mshr_busy    (mshr_busy),
    .mshr_idx     (mshr_idx),
    .fl_st        (fl_st)
);

// File: tb/sim_icl1_line_ctrl.sv
`timescale 1ns/1ps
module sim_icl1_line_ctrl;
    localparam int AW = 8;
    localparam int IW = 2;
    localparam int DW = 16;
    localparam int NL = 1 << IW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_evict = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          fill_valid = 1'b0;
    logic [DW-1:0] fill_data = '0;
    logic          tag_rd, tag_wr, data_wr, inv_done, resp_valid;
    logic [DW-1:0] resp_data;

    always #2 clk = ~clk;

    icl1_line_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_evict(req_evict), .req_addr(req_addr),
        .req_ready(req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .tag_rd(tag_rd), .tag_wr(tag_wr), .data_wr(data_wr),
        .inv_done(inv_done), .resp_valid(resp_valid), .resp_data(resp_data)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // bench line model: 0 empty, 1 waiting, 2 usable
    int             m_st  [NL];
    logic [AW-IW-1:0] m_tag [NL];
    logic [DW-1:0]  m_dat [NL];
    bit             m_pend;
    logic [IW-1:0]  m_pidx;

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fdat(input logic [AW-1:0] a, input int salt);
        return {a, ~a} ^ DW'(salt * 16'h1357) ^ 16'h3C5A;
    endfunction

    // one cycle of stimulus with model prediction and full output check
    task automatic cyc(input bit v, input bit ev, input logic [AW-1:0] a,
                       input bit f, input logic [DW-1:0] fd);
        logic [IW-1:0] ix;
        logic [AW-IW-1:0] tg;
        bit e_rdy, e_trd, e_twr, e_mem, e_inv, e_dwr, e_rsp;
        logic [DW-1:0] e_rdat;
        string rq;
        ix = a[IW-1:0];
        tg = a[AW-1:IW];
        {e_rdy, e_trd, e_twr, e_mem, e_inv, e_dwr, e_rsp} = '0;
        e_rdat = resp_data;
        rq = "R7";
        if (f) begin
            if (m_pend) begin
                e_rsp = 1; e_rdat = fd;
                if (m_st[m_pidx] == 1) begin
                    e_dwr = 1; m_st[m_pidx] = 2; m_dat[m_pidx] = fd; rq = "R3";
                end else begin
                    rq = "R6";
                end
                m_pend = 0;
            end else begin
                rq = "R9";
            end
            if (v) rq = "R8";
        end else if (v) begin
            if (ev) begin
                rq = (m_st[ix] != 0 && m_tag[ix] != tg) ? "R5" : "R4";
                e_rdy = 1; e_trd = 1; e_twr = 1; e_inv = 1;
                m_st[ix] = 0;
            end else if (m_st[ix] == 2 && m_tag[ix] == tg) begin
                rq = "R3";
                e_rdy = 1; e_trd = 1; e_rsp = 1; e_rdat = m_dat[ix];
            end else if (m_pend) begin
                rq = "R7";
            end else begin
                rq = (m_st[ix] == 2) ? "R10" : "R2";
                e_rdy = 1; e_trd = 1; e_twr = 1; e_mem = 1;
                m_st[ix] = 1; m_tag[ix] = tg; m_pend = 1; m_pidx = ix;
            end
        end
        req_valid = v; req_evict = ev; req_addr = a;
        fill_valid = f; fill_data = fd;
        #1;
        chk(rq, "req_ready", 32'(req_ready), 32'(e_rdy));
        @(negedge clk);
        req_valid = 0; fill_valid = 0;
        chk(rq, "tag_rd", 32'(tag_rd), 32'(e_trd));
        chk(rq, "tag_wr", 32'(tag_wr), 32'(e_twr));
        chk(rq, "mem_req_valid", 32'(mem_req_valid), 32'(e_mem));
        if (e_mem) chk(rq, "mem_req_addr", 32'(mem_req_addr), 32'(a));
        chk(rq, "inv_done", 32'(inv_done), 32'(e_inv));
        chk(rq, "data_wr", 32'(data_wr), 32'(e_dwr));
        chk(rq, "resp_valid", 32'(resp_valid), 32'(e_rsp));
        if (e_rsp) chk(rq, "resp_data", 32'(resp_data), 32'(e_rdat));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [15:0] r;
        for (int i = 0; i < NL; i++) begin
            m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0;
        end
        m_pend = 0; m_pidx = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state of outputs
        chk("R1", "reset outputs",
            32'({tag_rd, tag_wr, data_wr, inv_done, mem_req_valid, resp_valid}), 32'd0);
        chk("R1", "reset resp_data", 32'(resp_data), 32'd0);
        // R1: first fetch after reset misses
        cyc(1, 0, 8'h04, 0, '0);
        chk("R1", "first fetch missed", 32'(m_pend), 32'd1);
        cyc(0, 0, 8'h00, 1, fdat(8'h04, 0));

        // per-line miss, hold, fill, hit
        for (int i = 0; i < NL; i++) begin
            logic [AW-1:0] a0;
            a0 = AW'(((i + 2) << IW) | i);
            cyc(1, 0, a0, 0, '0);                        // R2 miss
            cyc(1, 0, a0, 0, '0);                        // R7 same line held
            cyc(1, 0, a0 ^ 8'h40, 0, '0);                // R7 other miss held
            cyc(1, 0, 8'h04, 0, '0);                     // hit on line 0 or held
            cyc(1, 1, a0, 1, fdat(a0, i));               // R8 fill wins
            cyc(1, 0, a0, 0, '0);                        // R3 hit
        end
        cyc(0, 0, '0, 1, 16'hBEEF);                      // R9 stray fill

        // late fill and tag-mismatch paths for every line
        for (int i = 0; i < NL; i++) begin
            logic [AW-1:0] a1;
            a1 = AW'(((i + 9) << IW) | i);
            cyc(1, 0, a1, 0, '0);                        // R10 tag differs
            cyc(1, 1, a1 ^ 8'h80, 0, '0);                // R5 evict by index
            cyc(1, 1, a1, 0, '0);                        // R4 evict empty line
            cyc(1, 0, a1, 0, '0);                        // R7 held
            cyc(0, 0, '0, 1, fdat(a1, 7));               // R6 late fill
            cyc(1, 0, a1, 0, '0);                        // R6 line still empty: miss
            cyc(0, 0, '0, 1, fdat(a1, 3));               // R3 fill
            cyc(1, 1, a1, 0, '0);                        // R4 evict usable line
            cyc(1, 0, a1, 0, '0);                        // R4 misses again
            cyc(0, 0, '0, 1, fdat(a1, 5));
        end

        // arithmetic stream sweep
        r = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            bit v, ev, f;
            logic [AW-1:0] a;
            r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
            v  = r[0] | r[1];
            ev = (r[4:2] == 3'd0);
            a  = {4'b0, r[9:8], r[11:10]};
            f  = (m_pend && r[14:12] == 3'd0) || (r[15] && r[5] && r[6] && r[7]);
            cyc(v, ev, a, f, fdat(a, k));
        end

        done = 1;
        summary();
    end
endmodule